// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small dual-clock microcontroller are running at any moment. The CPU writes a 4-bit mode code with a one-cycle strobe. The sequencer then moves between the run modes (NORMAL, SLOW2, SLOW1) and the standby modes (STOP, IDLE0/1/2, SLEEP0/1/2). It drives gate enables for the CPU clock, the high- and low-frequency peripheral clocks and the time-base timer tick. It also drives run enables for both oscillators and a select that tells the clock generator whether the CPU runs from the low-frequency clock.

Each standby mode has its own way out:
- STOP leaves only on a dedicated external release pin. It then passes through a warm-up phase of programmable length before the CPU clock opens again.
- IDLE0 and SLEEP0 leave on a falling edge of the time-base source clock.
- The other IDLE and SLEEP modes leave on any pending interrupt.

Every standby mode returns to the run mode it was entered from. A request that is illegal, or not allowed from the current mode, changes nothing and produces a one-cycle error pulse.

Top module: `pm_seq`

## Requirements
- R1: After reset the mode reads NORMAL (code 0). All gate and oscillator enables are 1, the low-frequency select is 0 and the error pulse is 0.
- R2: Mode codes are NORMAL=0, SLOW1=1, SLOW2=2, STOP=3, IDLE0=4, IDLE1=5, IDLE2=6, SLEEP0=8, SLEEP1=9, SLEEP2=10 and warm-up=15. An accepted request shows on `mode_o` after the clock edge that samples the strobe. The allowed moves are:
  - NORMAL from NORMAL or SLOW2;
  - SLOW2 from any run mode;
  - SLOW1 from SLOW1 or SLOW2;
  - STOP from any run mode;
  - IDLE0/1/2 from NORMAL only;
  - SLEEP0/1 from SLOW1 or SLOW2;
  - SLEEP2 from SLOW2 only.
- R3: A strobed code that is unassigned (7, 11 to 15) or not allowed by R2 leaves every output unchanged. It raises `req_err` for exactly the one cycle after the strobe.
- R4: With `dual_clk_en` low, requests for SLOW1, SLOW2 and any SLEEP mode are refused as in R3.
- R5: In STOP every gate, both oscillator enables and the tick enable are 0. STOP is held until `stop_release` is sampled high; interrupts and time-base edges have no effect.
- R6: On STOP release the mode reads 15 for `warmup_cycles`+1 cycles, then returns to the run mode active before STOP. During warm-up the CPU, peripheral and tick gates are 0, the low-frequency oscillator is on, and the high-frequency oscillator is on unless returning to SLOW1.
- R7: IDLE0 and SLEEP0 are released only by a sampled high-to-low change of `tbt_src`. Interrupts are ignored in these modes.
- R8: IDLE1, IDLE2, SLEEP1 and SLEEP2 are held while `irq_pending` is low. They return to the originating run mode on the edge that samples it high.
- R9: Enables per mode, as CPU/periph-HF/periph-LF/HF-osc/LF-osc/tick:
  - NORMAL and SLOW2: all 1;
  - SLOW1: 1/0/1/0/1/1;
  - IDLE0: 0/0/0/1/1/1;
  - IDLE1: 0/1/0/1/1/1;
  - IDLE2 and SLEEP2: 0/1/1/1/1/1;
  - SLEEP0: 0/0/0/h/1/1;
  - SLEEP1: 0/0/1/h/1/1, where h is 1 only when entered from SLOW2.

  `cpu_lf_sel` is 1 whenever the remembered run mode is SLOW1 or SLOW2.
- R10: Any request made while the CPU is halted (STOP, warm-up, IDLE, SLEEP) is refused as in R3 and does not block a release in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| dual_clk_en | input | 1 | 1 = dual-clock configuration |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 4 | Requested mode code |
| stop_release | input | 1 | External STOP release |
| irq_pending | input | 1 | Any enabled interrupt pending |
| tbt_src | input | 1 | Selected time-base source clock level |
| warmup_cycles | input | WARM_W | Warm-up length after STOP |
| mode_o | output | 4 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_hf_clk_en | output | 1 | Peripheral high-frequency clock gate |
| per_lf_clk_en | output | 1 | Peripheral low-frequency clock gate |
| hf_osc_en | output | 1 | High-frequency oscillator run |
| lf_osc_en | output | 1 | Low-frequency oscillator run |
| tbt_en | output | 1 | Time-base timer tick enable |
| cpu_lf_sel | output | 1 | CPU runs from low-frequency clock |
| req_err | output | 1 | Refused request pulse |

## Verification
Mode changes and the enable outputs follow from the registered mode, so they are due one clock edge after the strobe, interrupt, release or time-base edge that caused them. `req_err` is due in the cycle right after the strobe. The warm-up code stays for `warmup_cycles`+1 cycles before the return. The bench drives inputs just after a falling edge and advances its own model by one clock edge. It then compares mode, enables and error at the next falling edge, so every result is checked in exactly the cycle it becomes due.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [3:0] {
    PM_NORMAL = 4'd0,
    PM_SLOW1  = 4'd1,
    PM_SLOW2  = 4'd2,
    PM_STOP   = 4'd3,
    PM_IDLE0  = 4'd4,
    PM_IDLE1  = 4'd5,
    PM_IDLE2  = 4'd6,
    PM_SLEEP0 = 4'd8,
    PM_SLEEP1 = 4'd9,
    PM_SLEEP2 = 4'd10,
    PM_WARM   = 4'd15
  } pm_mode_e;

  typedef struct packed {
    logic cpu;
    logic per_hf;
    logic per_lf;
    logic hf_osc;
    logic lf_osc;
    logic tbt;
    logic lf_sel;
  } pm_gate_t;

  // CPU is clocked in these modes
  function automatic logic pm_is_run(pm_mode_e m);
    return (m == PM_NORMAL) || (m == PM_SLOW1) || (m == PM_SLOW2);
  endfunction

  function automatic logic pm_is_slow(pm_mode_e m);
    return (m == PM_SLOW1) || (m == PM_SLOW2);
  endfunction

  // Standby modes woken by a time-base falling edge
  function automatic logic pm_tick_wake(pm_mode_e m);
    return (m == PM_IDLE0) || (m == PM_SLEEP0);
  endfunction

  // Standby modes woken by an interrupt
  function automatic logic pm_irq_wake(pm_mode_e m);
    return (m == PM_IDLE1) || (m == PM_IDLE2) ||
           (m == PM_SLEEP1) || (m == PM_SLEEP2);
  endfunction

  // Legality of a requested code from the current mode
  function automatic logic pm_req_legal(pm_mode_e cur, logic [3:0] code, logic dual);
    logic ok;
    ok = 1'b0;
    if (pm_is_run(cur)) begin
      case (code)
        4'd0:           ok = (cur != PM_SLOW1);
        4'd1:           ok = dual && pm_is_slow(cur);
        4'd2:           ok = dual;
        4'd3:           ok = 1'b1;
        4'd4, 4'd5, 4'd6: ok = (cur == PM_NORMAL);
        4'd8, 4'd9:     ok = dual && pm_is_slow(cur);
        4'd10:          ok = dual && (cur == PM_SLOW2);
        default:        ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/pm_req_check.sv
module pm_req_check
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pm_mode_e   cur,
  input  logic       dual,
  input  logic       valid,
  input  logic [3:0] code,
  output logic       accept,
  output logic       reject
);

  logic legal;

  always_comb begin
    legal  = pm_req_legal(cur, code, dual);
    accept = valid && legal;
    reject = valid && !legal;
  end

  // Requests while the CPU is halted are always refused
  assert_halted_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pm_is_run(cur)) |-> (reject && !accept));

  // Unassigned codes never get through
  assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (code == 4'd7 || code >= 4'd11)) |-> !accept);

endmodule

// File: rtl/pm_warmup.sv
module pm_warmup #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         active,
  output logic         done
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= ZERO;
    else if (load)                      cnt_q <= load_val;
    else if (active && cnt_q != ZERO)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = active && (cnt_q == ZERO);

  // A nonzero load must not finish on the next cycle
  assert_warm_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != ZERO) |=> !done);

  // Warm-up is left only through done
  assert_warm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> active);

endmodule

// File: rtl/pm_gate_dec.sv
module pm_gate_dec
  import pm_pkg::*;
(
  input  pm_mode_e st,
  input  pm_mode_e ret,
  output pm_gate_t gate
);

  logic hf_for_sleep;
  logic hf_for_warm;

  always_comb begin
    hf_for_sleep = (ret == PM_SLOW2);
    hf_for_warm  = (ret != PM_SLOW1);
    gate         = '0;
    gate.lf_sel  = pm_is_slow(ret);
    case (st)
      PM_NORMAL, PM_SLOW2: begin
        gate.cpu = 1'b1; gate.per_hf = 1'b1; gate.per_lf = 1'b1;
        gate.hf_osc = 1'b1; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_SLOW1: begin
        gate.cpu = 1'b1; gate.per_lf = 1'b1; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_WARM: begin
        gate.hf_osc = hf_for_warm; gate.lf_osc = 1'b1;
      end
      PM_IDLE0: begin
        gate.hf_osc = 1'b1; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_IDLE1: begin
        gate.per_hf = 1'b1; gate.hf_osc = 1'b1; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_IDLE2, PM_SLEEP2: begin
        gate.per_hf = 1'b1; gate.per_lf = 1'b1; gate.hf_osc = 1'b1;
        gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_SLEEP0: begin
        gate.hf_osc = hf_for_sleep; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      PM_SLEEP1: begin
        gate.per_lf = 1'b1; gate.hf_osc = hf_for_sleep; gate.lf_osc = 1'b1; gate.tbt = 1'b1;
      end
      default: gate.lf_sel = pm_is_slow(ret);
    endcase
  end

endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
#(
  parameter int WARM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_clk_en,
  input  logic              req_valid,
  input  logic [3:0]        req_code,
  input  logic              stop_release,
  input  logic              irq_pending,
  input  logic              tbt_src,
  input  logic [WARM_W-1:0] warmup_cycles,
  output logic [3:0]        mode_o,
  output logic              cpu_clk_en,
  output logic              per_hf_clk_en,
  output logic              per_lf_clk_en,
  output logic              hf_osc_en,
  output logic              lf_osc_en,
  output logic              tbt_en,
  output logic              cpu_lf_sel,
  output logic              req_err
);

  pm_mode_e st_q, st_d;
  pm_mode_e ret_q, ret_d;
  logic     tbt_q;
  logic     tbt_fall;
  logic     req_ok, req_bad;
  logic     warm_load, warm_active, warm_done;
  logic     err_q;
  pm_gate_t gate;

  // Named internal events
  assign tbt_fall    = tbt_q && !tbt_src;
  assign warm_active = (st_q == PM_WARM);
  assign warm_load   = (st_q == PM_STOP) && stop_release;

  pm_req_check u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur    (st_q),
    .dual   (dual_clk_en),
    .valid  (req_valid),
    .code   (req_code),
    .accept (req_ok),
    .reject (req_bad)
  );

  pm_warmup #(.W(WARM_W)) u_warm (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (warm_load),
    .load_val (warmup_cycles),
    .active   (warm_active),
    .done     (warm_done)
  );

  pm_gate_dec u_gate (
    .st   (st_q),
    .ret  (ret_q),
    .gate (gate)
  );

  always_comb begin
    st_d  = st_q;
    ret_d = ret_q;
    if (req_ok) begin
      st_d = pm_mode_e'(req_code);
      if (pm_is_run(st_d)) ret_d = st_d;
    end else begin
      case (st_q)
        PM_STOP:  if (stop_release) st_d = PM_WARM;
        PM_WARM:  if (warm_done)    st_d = ret_q;
        default: begin
          if (pm_tick_wake(st_q) && tbt_fall)   st_d = ret_q;
          if (pm_irq_wake(st_q) && irq_pending) st_d = ret_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PM_NORMAL;
      ret_q <= PM_NORMAL;
      tbt_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      tbt_q <= tbt_src;
      err_q <= req_bad;
    end
  end

  assign mode_o        = st_q;
  assign cpu_clk_en    = gate.cpu;
  assign per_hf_clk_en = gate.per_hf;
  assign per_lf_clk_en = gate.per_lf;
  assign hf_osc_en     = gate.hf_osc;
  assign lf_osc_en     = gate.lf_osc;
  assign tbt_en        = gate.tbt;
  assign cpu_lf_sel    = gate.lf_sel;
  assign req_err       = err_q;

  assert_cpu_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (hf_osc_en || lf_osc_en));

  assert_hf_periph_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    per_hf_clk_en |-> hf_osc_en);

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid));

  assert_single_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dual_clk_en && (req_code == 4'd1 || req_code == 4'd2 ||
     req_code == 4'd8 || req_code == 4'd9 || req_code == 4'd10)) |=> req_err);

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_STOP && !stop_release) |=> (mode_o == PM_STOP && !hf_osc_en && !lf_osc_en));

  assert_stop_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_STOP && stop_release) |=> (mode_o == PM_WARM && !cpu_clk_en));

  assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_IDLE0 && !tbt_fall) |=> (mode_o == PM_IDLE0));

  assert_irq_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_IDLE1 && !irq_pending) |=> (mode_o == PM_IDLE1));

endmodule

// File: tb/tb_pm_seq.sv
`timescale 1ns/1ps
module tb_pm_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual = 1'b1;
  logic rv = 1'b0;
  logic [3:0] rc = 4'd0;
  logic sr = 1'b0;
  logic irq = 1'b0;
  logic tbt = 1'b0;
  logic [15:0] wu = 16'd0;

  logic [3:0] mode;
  logic cpu_en, phf_en, plf_en, hfo_en, lfo_en, tbt_en, lf_sel, err;

  int total = 0;
  int bad = 0;
  string tag_m = "R2";

  // model state
  logic [3:0] m_st = 4'd0;
  logic [3:0] m_ret = 4'd0;
  int m_cnt = 0;
  bit m_tq = 1'b0;
  bit m_err = 1'b0;

  always #10 clk = ~clk;

  pm_seq #(.WARM_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .dual_clk_en(dual), .req_valid(rv), .req_code(rc),
    .stop_release(sr), .irq_pending(irq), .tbt_src(tbt), .warmup_cycles(wu),
    .mode_o(mode), .cpu_clk_en(cpu_en), .per_hf_clk_en(phf_en),
    .per_lf_clk_en(plf_en), .hf_osc_en(hfo_en), .lf_osc_en(lfo_en),
    .tbt_en(tbt_en), .cpu_lf_sel(lf_sel), .req_err(err)
  );

  function automatic bit b_legal(logic [3:0] cur, logic [3:0] c, bit d);
    bit slow;
    slow = (cur == 4'd1) || (cur == 4'd2);
    if (cur > 4'd2) return 1'b0;
    case (c)
      4'd0: return cur != 4'd1;
      4'd2: return d;
      4'd3: return 1'b1;
      4'd1, 4'd8, 4'd9: return d && slow;
      4'd10: return d && (cur == 4'd2);
      4'd4, 4'd5, 4'd6: return cur == 4'd0;
      default: return 1'b0;
    endcase
  endfunction

  // {cpu, per_hf, per_lf, hf_osc, lf_osc, tick, lf_sel}
  function automatic logic [6:0] b_gates(logic [3:0] st, logic [3:0] ret);
    logic [5:0] g;
    bit h;
    h = (ret == 4'd2);
    case (st)
      4'd0, 4'd2:  g = 6'b111111;
      4'd1:        g = 6'b101011;
      4'd3:        g = 6'b000000;
      4'd15:       g = {3'b000, ret != 4'd1, 2'b10};
      4'd4:        g = 6'b000111;
      4'd5:        g = 6'b010111;
      4'd6, 4'd10: g = 6'b011111;
      4'd8:        g = {3'b000, h, 2'b11};
      4'd9:        g = {3'b001, h, 2'b11};
      default:     g = 6'b000000;
    endcase
    return {g, ret != 4'd0};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit fall, acc;
    logic [3:0] ns, nr;
    int nc;
    fall = m_tq && !tbt;
    acc = rv && b_legal(m_st, rc, dual);
    ns = m_st; nr = m_ret; nc = m_cnt;
    if (acc) begin
      ns = rc;
      if (rc <= 4'd2) nr = rc;
    end else begin
      case (m_st)
        4'd3: if (sr) begin ns = 4'd15; nc = wu; end
        4'd15: if (m_cnt == 0) ns = m_ret; else nc = m_cnt - 1;
        4'd4, 4'd8: if (fall) ns = m_ret;
        4'd5, 4'd6, 4'd9, 4'd10: if (irq) ns = m_ret;
        default: ;
      endcase
    end
    m_err = rv && !acc;
    m_tq = tbt;
    m_st = ns; m_ret = nr; m_cnt = nc;
    @(negedge clk);
    chk(tag_m, mode, m_st);
    chk("R9", {cpu_en, phf_en, plf_en, hfo_en, lfo_en, tbt_en, lf_sel}, b_gates(m_st, m_ret));
    chk("R3", err, m_err);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic req(logic [3:0] c);
    rv = 1'b1; rc = c;
    cyc();
    rv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", mode, 0);
    chk("R1", {cpu_en, phf_en, plf_en, hfo_en, lfo_en, tbt_en, lf_sel}, 7'b1111110);
    chk("R1", err, 0);

    // R8 IDLE1 holds without interrupt, irq returns to NORMAL
    tag_m = "R8";
    req(4'd5); idle(4);
    chk("R8", mode, 5);
    irq = 1'b1; cyc(); irq = 1'b0;
    chk("R8", mode, 0);

    // R7 IDLE0 ignores irq, rising tick edge, leaves on falling edge
    tag_m = "R7";
    req(4'd4);
    irq = 1'b1; idle(3); irq = 1'b0;
    tbt = 1'b1; idle(2);
    chk("R7", mode, 4);
    tbt = 1'b0; cyc();
    chk("R7", mode, 0);

    // R3 unassigned codes
    tag_m = "R3";
    req(4'd7); req(4'd11); req(4'd15);
    chk("R3", mode, 0);

    // R4 single clock refuses slow and sleep
    tag_m = "R4";
    dual = 1'b0;
    req(4'd2);
    chk("R4", err, 1);
    chk("R4", mode, 0);
    cyc();
    chk("R4", err, 0);
    dual = 1'b1;

    // R2 NORMAL->SLOW2->SLOW1, direct SLOW1->NORMAL refused
    tag_m = "R2";
    req(4'd8);
    chk("R2", err, 1);
    req(4'd2); req(4'd1);
    chk("R2", mode, 1);
    req(4'd0);
    chk("R2", mode, 1);
    req(4'd10);
    chk("R2", mode, 1);

    // R8 SLEEP1 from SLOW1 returns to SLOW1
    tag_m = "R8";
    req(4'd9); idle(2);
    irq = 1'b1; cyc(); irq = 1'b0;
    chk("R8", mode, 1);

    // R5 / R6 STOP from SLOW1 with warm-up of 3
    tag_m = "R5";
    wu = 16'd3;
    req(4'd3);
    irq = 1'b1; tbt = 1'b1; idle(3); irq = 1'b0; tbt = 1'b0; idle(2);
    chk("R5", mode, 3);
    tag_m = "R6";
    sr = 1'b1; cyc(); sr = 1'b0;
    chk("R6", hfo_en, 0);
    idle(3);
    chk("R6", mode, 15);
    cyc();
    chk("R6", mode, 1);

    // R10 requests while halted
    tag_m = "R10";
    req(4'd2); req(4'd0);
    req(4'd5);
    req(4'd2);
    chk("R10", err, 1);
    chk("R10", mode, 5);
    rv = 1'b1; rc = 4'd0; irq = 1'b1; cyc(); rv = 1'b0; irq = 1'b0;
    chk("R10", mode, 0);

    // R6 zero warm-up from NORMAL
    tag_m = "R6";
    wu = 16'd0;
    req(4'd3);
    sr = 1'b1; cyc(); sr = 1'b0;
    chk("R6", mode, 15);
    cyc();
    chk("R6", mode, 0);

    // constrained random
    tag_m = "R2";
    for (int n = 0; n < 4000; n++) begin
      rv = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) rc = 4'($urandom % 16);
      else begin
        case ($urandom % 6)
          0: rc = 4'd0;
          1: rc = 4'd1;
          2: rc = 4'd2;
          3: rc = 4'd3;
          4: rc = 4'(4 + $urandom % 3);
          default: rc = 4'(8 + $urandom % 3);
        endcase
      end
      irq = ($urandom % 6) == 0;
      sr = ($urandom % 5) == 0;
      if (($urandom % 3) == 0) tbt = ~tbt;
      wu = 16'($urandom % 8);
      if (($urandom % 200) == 0) dual = ~dual;
      cyc();
    end
    rv = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule